// File: doc/BRIEF.md
# Card Host Register Front End with Dual Interrupts

This block is the register-access side of a memory-card host controller. A simple single-cycle bus (valid, write enable, 12-bit byte address, 32-bit data) reaches a 4 KB window of word registers. The block stores the software-programmed settings and presents them as outputs: power, clock divider, command argument, command word, data timer, data length and data control. It also gives read-only views of values owned by the command and data engines: four response words, the remaining byte count, the FIFO word count and the FIFO data window. Eight identification bytes sit in the last eight words of the window.

The status word has two halves. Bits 10:0 are sticky event flags. The command and data engines raise them with one-cycle set pulses, and software lowers them through a write-one-to-clear register. Bits 21:11 are live FIFO and activity flags that follow an input. Two mask registers each select any part of the status word, and each one drives its own level interrupt line. Writes to the command register, the data-control register and the FIFO window raise one-cycle strobes, so the neighbouring engines can act on them.

Top module: `card_host_regs`

## Requirements
- R1: After reset all stored registers, both masks and the sticky status bits are zero, and both interrupt lines are low.
- R2: The stored registers are read back at word offsets power 0x00, clock 0x04, argument 0x08, command 0x0C, data timer 0x24, data length 0x28, data control 0x2C, mask 0 0x3C and mask 1 0x40. Read data appears on the read-data port with the read-valid flag high in the cycle after the request.
- R3: Writes keep only bits 7:0 for power, clock and data control, only bits 15:0 for data length, and only bits 21:0 for the two masks. Argument, command and data timer keep all 32 bits. The kept values drive the matching output ports.
- R4: A status read at 0x34 returns the sticky bits in 10:0, the live-flag input in 21:11 and zero in 31:22. A set pulse on sts_set bit b sets sticky bit b, with one exception: bit 9 is reserved and always reads 0.
- R5: A write to the clear register at 0x38 clears each sticky bit whose written bit is 1. Only bits 10:0 act. If a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: Interrupt line i (i = 0, 1) is high exactly when (status word AND mask i) is non-zero. It is computed from the registered status and masks, and each line follows only its own mask.
- R7: Reads at byte offsets 0xFE0, 0xFE4 … 0xFFC return, one per word in the low byte, 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: Response word k (k = 0..3) reads at 0x14 + 4k from resp_words[32k+31:32k]. Data count reads at 0x30 and FIFO count at 0x48, both zero-extended. Writes to these offsets, to status and to the identification words change nothing.
- R9: A read in the FIFO window 0x80–0xBC returns fifo_rdata and pulses fifo_rd_stb for one cycle in the following cycle. A write there pulses fifo_wr_stb in the following cycle, with the written word on fifo_wdata.
- R10: A write to 0x0C pulses cmd_go_stb, and a write to 0x2C pulses data_go_stb, each for one cycle in the cycle after the write.
- R11: Any other word offset, and any address with bits 1:0 not zero, reads as zero. A write there changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| sts_set | input | 11 | One-cycle set pulses for sticky status bits |
| live_flags | input | 11 | Live flags shown in status bits 21:11 |
| resp_words | input | 128 | Four response words from the command engine |
| data_count | input | 16 | Remaining byte count from the data engine |
| fifo_count | input | 16 | FIFO word count from the data engine |
| fifo_rdata | input | 32 | Word at the head of the receive FIFO |
| fifo_rd_stb | output | 1 | FIFO pop request |
| fifo_wr_stb | output | 1 | FIFO push request |
| fifo_wdata | output | 32 | Word to push |
| cmd_go_stb | output | 1 | Command register was written |
| data_go_stb | output | 1 | Data control register was written |
| power_q | output | 8 | Power setting |
| clock_q | output | 8 | Clock setting |
| arg_q | output | 32 | Command argument |
| cmd_q | output | 32 | Command word |
| dtimer_q | output | 32 | Data timeout value |
| dlen_q | output | 16 | Data length |
| dctrl_q | output | 8 | Data control |
| irq | output | 2 | Level interrupt lines |

## Verification
The hardest case to reach from the ports is a set pulse and a clear write that hit the same sticky bit on the same clock edge. The bench drives the pulse and the bus write from the same negative edge, so both land on the next rising edge, and then reads the status word back. A second hard case is the full address space. The bench walks every one of the 1024 word offsets and compares each one with its own map of offsets. It writes all ones to each unmapped word and reads the word back, and it then confirms that no stored register moved and no strobe fired.

// File: rtl/chr_pkg.sv
package chr_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_POWER,
    SEL_CLOCK,
    SEL_ARG,
    SEL_CMD,
    SEL_RESP,
    SEL_TIMER,
    SEL_LEN,
    SEL_CTRL,
    SEL_DCNT,
    SEL_STATUS,
    SEL_CLEAR,
    SEL_MASK,
    SEL_FCNT,
    SEL_FIFO,
    SEL_ID
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [3:0] sub;
  } dec_t;

  // identification byte k of the eight-word tail of the window
  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0:    id_byte = 8'h81;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/chr_decode.sv
module chr_decode
  import chr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_RESP = 4,
  parameter int NUM_IRQ  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam int WIDX_W    = ADDR_W - 2;
  localparam int RESP_BASE = 5;
  localparam int MASK_BASE = 15;
  localparam int FIFO_BASE = 32;
  localparam int FIFO_LEN  = 16;
  localparam int ID_BASE   = (1 << WIDX_W) - 8;

  logic [WIDX_W-1:0] widx;
  int                w;

  assign widx = addr_i[ADDR_W-1:2];
  assign w    = int'(widx);

  always_comb begin
    dec_o.sel = SEL_NONE;
    dec_o.sub = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (w == 0)       dec_o.sel = SEL_POWER;
      else if (w == 1)  dec_o.sel = SEL_CLOCK;
      else if (w == 2)  dec_o.sel = SEL_ARG;
      else if (w == 3)  dec_o.sel = SEL_CMD;
      else if (w >= RESP_BASE && w < RESP_BASE + NUM_RESP) begin
        dec_o.sel = SEL_RESP;
        dec_o.sub = 4'(w - RESP_BASE);
      end
      else if (w == 9)  dec_o.sel = SEL_TIMER;
      else if (w == 10) dec_o.sel = SEL_LEN;
      else if (w == 11) dec_o.sel = SEL_CTRL;
      else if (w == 12) dec_o.sel = SEL_DCNT;
      else if (w == 13) dec_o.sel = SEL_STATUS;
      else if (w == 14) dec_o.sel = SEL_CLEAR;
      else if (w >= MASK_BASE && w < MASK_BASE + NUM_IRQ) begin
        dec_o.sel = SEL_MASK;
        dec_o.sub = 4'(w - MASK_BASE);
      end
      else if (w == 18) dec_o.sel = SEL_FCNT;
      else if (w >= FIFO_BASE && w < FIFO_BASE + FIFO_LEN) dec_o.sel = SEL_FIFO;
      else if (w >= ID_BASE) begin
        dec_o.sel = SEL_ID;
        dec_o.sub = 4'(w - ID_BASE);
      end
    end
  end
endmodule

// File: rtl/chr_status.sv
module chr_status #(
  parameter int STICKY_W = 11,
  parameter int LIVE_W   = 11,
  parameter int RSV_BIT  = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [STICKY_W-1:0]        set_i,
  input  logic                       clr_en_i,
  input  logic [STICKY_W-1:0]        clr_bits_i,
  input  logic [LIVE_W-1:0]          live_i,
  output logic [STICKY_W-1:0]        sticky_o,
  output logic [STICKY_W+LIVE_W-1:0] status_o
);
  localparam logic [STICKY_W-1:0] RSV_MASK = STICKY_W'(1) << RSV_BIT;

  // clear first, then set, so a simultaneous set survives
  function automatic logic [STICKY_W-1:0] next_sticky(
    input logic [STICKY_W-1:0] q,
    input logic [STICKY_W-1:0] set,
    input logic                clr_en,
    input logic [STICKY_W-1:0] clr
  );
    logic [STICKY_W-1:0] kill;
    kill = clr_en ? clr : '0;
    return ((q & ~kill) | set) & ~RSV_MASK;
  endfunction

  logic [STICKY_W-1:0] sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= next_sticky(sticky_q, set_i, clr_en_i, clr_bits_i);
  end

  assign sticky_o = sticky_q;
  assign status_o = {live_i, sticky_q};
endmodule

// File: rtl/chr_irq.sv
module chr_irq #(
  parameter int STATUS_W = 22,
  parameter int NUM_IRQ  = 2
) (
  input  logic [STATUS_W-1:0]         status_i,
  input  logic [NUM_IRQ*STATUS_W-1:0] masks_i,
  output logic [NUM_IRQ-1:0]          irq_o
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign irq_o[i] = |(status_i & masks_i[i*STATUS_W +: STATUS_W]);
  end
endmodule

// File: rtl/card_host_regs.sv
module card_host_regs
  import chr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int STICKY_W = 11,
  parameter int LIVE_W   = 11,
  parameter int RSV_BIT  = 9,
  parameter int NUM_IRQ  = 2,
  parameter int NUM_RESP = 4,
  parameter int NARROW_W = 8,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  input  logic [STICKY_W-1:0]      sts_set,
  input  logic [LIVE_W-1:0]        live_flags,
  input  logic [NUM_RESP*DATA_W-1:0] resp_words,
  input  logic [CNT_W-1:0]         data_count,
  input  logic [CNT_W-1:0]         fifo_count,
  input  logic [DATA_W-1:0]        fifo_rdata,
  output logic                     fifo_rd_stb,
  output logic                     fifo_wr_stb,
  output logic [DATA_W-1:0]        fifo_wdata,
  output logic                     cmd_go_stb,
  output logic                     data_go_stb,
  output logic [NARROW_W-1:0]      power_q,
  output logic [NARROW_W-1:0]      clock_q,
  output logic [DATA_W-1:0]        arg_q,
  output logic [DATA_W-1:0]        cmd_q,
  output logic [DATA_W-1:0]        dtimer_q,
  output logic [LEN_W-1:0]         dlen_q,
  output logic [NARROW_W-1:0]      dctrl_q,
  output logic [NUM_IRQ-1:0]       irq
);
  localparam int STATUS_W = STICKY_W + LIVE_W;

  // named events for the checker
  dec_t                        dec;
  logic                        wr_hit;
  logic                        rd_hit;
  logic                        clr_hit;
  logic                        cmd_hit;
  logic                        ctrl_hit;
  logic                        fifo_wr_hit;
  logic                        fifo_rd_hit;
  logic [STICKY_W-1:0]         sticky_q;
  logic [STATUS_W-1:0]         status_w;
  logic [STATUS_W-1:0]         mask_q [NUM_IRQ];
  logic [NUM_IRQ*STATUS_W-1:0] mask_flat;
  logic [DATA_W-1:0]           rd_word;

  chr_decode #(
    .ADDR_W(ADDR_W), .NUM_RESP(NUM_RESP), .NUM_IRQ(NUM_IRQ)
  ) u_dec (
    .addr_i(bus_addr),
    .dec_o (dec)
  );

  assign wr_hit      = bus_valid &  bus_write;
  assign rd_hit      = bus_valid & ~bus_write;
  assign clr_hit     = wr_hit & (dec.sel == SEL_CLEAR);
  assign cmd_hit     = wr_hit & (dec.sel == SEL_CMD);
  assign ctrl_hit    = wr_hit & (dec.sel == SEL_CTRL);
  assign fifo_wr_hit = wr_hit & (dec.sel == SEL_FIFO);
  assign fifo_rd_hit = rd_hit & (dec.sel == SEL_FIFO);

  chr_status #(
    .STICKY_W(STICKY_W), .LIVE_W(LIVE_W), .RSV_BIT(RSV_BIT)
  ) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (sts_set),
    .clr_en_i  (clr_hit),
    .clr_bits_i(bus_wdata[STICKY_W-1:0]),
    .live_i    (live_flags),
    .sticky_o  (sticky_q),
    .status_o  (status_w)
  );

  // settings registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_q  <= '0;
      clock_q  <= '0;
      arg_q    <= '0;
      cmd_q    <= '0;
      dtimer_q <= '0;
      dlen_q   <= '0;
      dctrl_q  <= '0;
    end else if (wr_hit) begin
      unique case (dec.sel)
        SEL_POWER: power_q  <= bus_wdata[NARROW_W-1:0];
        SEL_CLOCK: clock_q  <= bus_wdata[NARROW_W-1:0];
        SEL_ARG:   arg_q    <= bus_wdata;
        SEL_CMD:   cmd_q    <= bus_wdata;
        SEL_TIMER: dtimer_q <= bus_wdata;
        SEL_LEN:   dlen_q   <= bus_wdata[LEN_W-1:0];
        SEL_CTRL:  dctrl_q  <= bus_wdata[NARROW_W-1:0];
        default: ;
      endcase
    end
  end

  // one mask register per interrupt line
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[i] <= '0;
      else if (wr_hit && dec.sel == SEL_MASK && dec.sub == 4'(i))
        mask_q[i] <= bus_wdata[STATUS_W-1:0];
    end
    assign mask_flat[i*STATUS_W +: STATUS_W] = mask_q[i];
  end

  chr_irq #(
    .STATUS_W(STATUS_W), .NUM_IRQ(NUM_IRQ)
  ) u_irq (
    .status_i(status_w),
    .masks_i (mask_flat),
    .irq_o   (irq)
  );

  // read multiplexer
  always_comb begin
    rd_word = '0;
    unique case (dec.sel)
      SEL_POWER:  rd_word = DATA_W'(power_q);
      SEL_CLOCK:  rd_word = DATA_W'(clock_q);
      SEL_ARG:    rd_word = arg_q;
      SEL_CMD:    rd_word = cmd_q;
      SEL_TIMER:  rd_word = dtimer_q;
      SEL_LEN:    rd_word = DATA_W'(dlen_q);
      SEL_CTRL:   rd_word = DATA_W'(dctrl_q);
      SEL_DCNT:   rd_word = DATA_W'(data_count);
      SEL_FCNT:   rd_word = DATA_W'(fifo_count);
      SEL_STATUS: rd_word = DATA_W'(status_w);
      SEL_FIFO:   rd_word = fifo_rdata;
      SEL_ID:     rd_word = DATA_W'(id_byte(dec.sub[2:0]));
      SEL_RESP: begin
        for (int k = 0; k < NUM_RESP; k++)
          if (dec.sub == 4'(k)) rd_word = resp_words[k*DATA_W +: DATA_W];
      end
      SEL_MASK: begin
        for (int k = 0; k < NUM_IRQ; k++)
          if (dec.sub == 4'(k)) rd_word = DATA_W'(mask_q[k]);
      end
      default: rd_word = '0;
    endcase
  end

  // registered read response and strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      bus_rvalid  <= 1'b0;
      fifo_rd_stb <= 1'b0;
      fifo_wr_stb <= 1'b0;
      fifo_wdata  <= '0;
      cmd_go_stb  <= 1'b0;
      data_go_stb <= 1'b0;
    end else begin
      bus_rvalid  <= rd_hit;
      if (rd_hit) bus_rdata <= rd_word;
      fifo_rd_stb <= fifo_rd_hit;
      fifo_wr_stb <= fifo_wr_hit;
      if (fifo_wr_hit) fifo_wdata <= bus_wdata;
      cmd_go_stb  <= cmd_hit;
      data_go_stb <= ctrl_hit;
    end
  end
endmodule

// File: rtl/chr_checker.sv
module chr_checker #(
  parameter int STICKY_W = 11,
  parameter int STATUS_W = 22,
  parameter int NUM_IRQ  = 2,
  parameter int RSV_BIT  = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rd_hit,
  input logic                        bus_rvalid,
  input logic [STICKY_W-1:0]         sts_set,
  input logic                        clr_hit,
  input logic [STICKY_W-1:0]         clr_bits,
  input logic [STICKY_W-1:0]         sticky,
  input logic [STATUS_W-1:0]         status,
  input logic [NUM_IRQ*STATUS_W-1:0] masks,
  input logic [NUM_IRQ-1:0]          irq,
  input logic                        fifo_rd_hit,
  input logic                        fifo_rd_stb,
  input logic                        cmd_hit,
  input logic                        cmd_go_stb
);
  localparam logic [STICKY_W-1:0] RSV_MASK = STICKY_W'(1) << RSV_BIT;

  logic [STICKY_W-1:0] set_eff;
  logic [STICKY_W-1:0] clr_eff;
  assign set_eff = sts_set & ~RSV_MASK;
  assign clr_eff = clr_bits & ~sts_set;

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> bus_rvalid);
  assert_no_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> !bus_rvalid);
  assert_rsv_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky[RSV_BIT]);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((sticky & $past(set_eff)) == $past(set_eff)));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((sticky & $past(clr_eff)) == '0));
  assert_fifo_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_hit |=> fifo_rd_stb);
  assert_cmd_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> cmd_go_stb);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (masks[i*STATUS_W +: STATUS_W] == '0) |-> !irq[i]);
    assert_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> (!$stable(status) || !$stable(masks[i*STATUS_W +: STATUS_W])));
  end
endmodule

bind card_host_regs chr_checker #(
  .STICKY_W(STICKY_W), .STATUS_W(STATUS_W), .NUM_IRQ(NUM_IRQ), .RSV_BIT(RSV_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_hit     (rd_hit),
  .bus_rvalid (bus_rvalid),
  .sts_set    (sts_set),
  .clr_hit    (clr_hit),
  .clr_bits   (bus_wdata[STICKY_W-1:0]),
  .sticky     (sticky_q),
  .status     (status_w),
  .masks      (mask_flat),
  .irq        (irq),
  .fifo_rd_hit(fifo_rd_hit),
  .fifo_rd_stb(fifo_rd_stb),
  .cmd_hit    (cmd_hit),
  .cmd_go_stb (cmd_go_stb)
);

// File: tb/sim_card_host_regs.sv
`timescale 1ns/1ps
module sim_card_host_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0;
  logic         bus_write = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [10:0]  sts_set = '0;
  logic [10:0]  live_flags = '0;
  logic [127:0] resp_words = '0;
  logic [15:0]  data_count = '0;
  logic [15:0]  fifo_count = '0;
  logic [31:0]  fifo_rdata = '0;
  logic         fifo_rd_stb, fifo_wr_stb, cmd_go_stb, data_go_stb;
  logic [31:0]  fifo_wdata;
  logic [7:0]   power_q, clock_q, dctrl_q;
  logic [31:0]  arg_q, cmd_q, dtimer_q;
  logic [15:0]  dlen_q;
  logic [1:0]   irq;

  int n_chk = 0;
  int n_err = 0;
  int n_rd = 0, n_wr = 0, n_cmd = 0, n_dgo = 0;
  logic [31:0] last_fw = '0;

  always #10 clk = ~clk;

  card_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sts_set(sts_set), .live_flags(live_flags),
    .resp_words(resp_words), .data_count(data_count), .fifo_count(fifo_count),
    .fifo_rdata(fifo_rdata), .fifo_rd_stb(fifo_rd_stb), .fifo_wr_stb(fifo_wr_stb),
    .fifo_wdata(fifo_wdata), .cmd_go_stb(cmd_go_stb), .data_go_stb(data_go_stb),
    .power_q(power_q), .clock_q(clock_q), .arg_q(arg_q), .cmd_q(cmd_q),
    .dtimer_q(dtimer_q), .dlen_q(dlen_q), .dctrl_q(dctrl_q), .irq(irq)
  );

  always @(posedge clk) begin
    if (fifo_rd_stb) n_rd++;
    if (fifo_wr_stb) begin n_wr++; last_fw = fifo_wdata; end
    if (cmd_go_stb)  n_cmd++;
    if (data_go_stb) n_dgo++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk); sts_set = v;
    @(negedge clk); sts_set = '0;
  endtask

  // bench's own view of the address map
  function automatic logic [31:0] keep(input int off);
    case (off)
      'h00, 'h04, 'h2C: keep = 32'h0000_00FF;
      'h28:             keep = 32'h0000_FFFF;
      'h3C, 'h40:       keep = 32'h003F_FFFF;
      default:          keep = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic bit mapped(input int w);
    if (w <= 3 || (w >= 5 && w <= 16) || w == 18) return 1;
    if (w >= 32 && w <= 47) return 1;
    if (w >= 1016) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] status_exp(input logic [10:0] st, input logic [10:0] lv);
    return {10'd0, lv, st & ~11'h200};
  endfunction

  logic [7:0] id_tab [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
  int rw_offs [9] = '{'h00, 'h04, 'h08, 'h0C, 'h24, 'h28, 'h2C, 'h3C, 'h40};

  initial begin
    logic [31:0] d;
    logic [31:0] pats [3] = '{32'hFFFF_FFFF, 32'hA5C3_5A3C, 32'h1234_5678};
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (rw_offs[k]) begin
      rd(12'(rw_offs[k]), d);
      chk("R1 reset register", d, 32'd0);
    end
    rd(12'h034, d); chk("R1 reset status", d, 32'd0);
    chk("R1 reset irq", 32'(irq), 32'd0);

    // R2/R3 readback with masking
    foreach (pats[p]) begin
      foreach (rw_offs[k]) begin
        wr(12'(rw_offs[k]), pats[p]);
        rd(12'(rw_offs[k]), d);
        chk("R2 R3 readback", d, pats[p] & keep(rw_offs[k]));
      end
      chk("R3 power_q", 32'(power_q), pats[p] & 32'hFF);
      chk("R3 clock_q", 32'(clock_q), pats[p] & 32'hFF);
      chk("R3 arg_q", arg_q, pats[p]);
      chk("R3 cmd_q", cmd_q, pats[p]);
      chk("R3 dtimer_q", dtimer_q, pats[p]);
      chk("R3 dlen_q", 32'(dlen_q), pats[p] & 32'hFFFF);
      chk("R3 dctrl_q", 32'(dctrl_q), pats[p] & 32'hFF);
    end
    wr(12'h03C, 0); wr(12'h040, 0);

    // R10 strobes
    c0 = n_cmd;
    wr(12'h00C, 32'h55); @(negedge clk);
    chk("R10 cmd_go count", 32'(n_cmd - c0), 32'd1);
    c0 = n_dgo;
    wr(12'h02C, 32'h3); @(negedge clk);
    chk("R10 data_go count", 32'(n_dgo - c0), 32'd1);

    // R4/R5 sticky sweep
    live_flags = 11'h5A5;
    for (int b = 0; b < 11; b++) begin
      pulse(11'(1) << b);
      rd(12'h034, d);
      chk("R4 status set", d, status_exp(11'(1) << b, 11'h5A5));
      wr(12'h038, ~(32'(1) << b));
      rd(12'h034, d);
      chk("R5 clear other bits", d, status_exp(11'(1) << b, 11'h5A5));
      wr(12'h038, 32'(1) << b);
      rd(12'h034, d);
      chk("R5 clear bit", d, status_exp(11'd0, 11'h5A5));
    end
    // R5 high bits of clear have no effect
    pulse(11'h0F0);
    wr(12'h038, 32'hFFFF_F800);
    rd(12'h034, d);
    chk("R5 clear high bits ignored", d, status_exp(11'h0F0, 11'h5A5));
    // R5 set wins over clear in the same cycle
    @(negedge clk);
    sts_set = 11'h008; bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = 12'h038; bus_wdata = 32'h7FF;
    @(negedge clk);
    sts_set = '0; bus_valid = 1'b0; bus_write = 1'b0;
    rd(12'h034, d);
    chk("R5 set wins", d, status_exp(11'h008, 11'h5A5));
    wr(12'h038, 32'h7FF);

    // R6 interrupt sweep: all sticky set, live alternating
    pulse(11'h7FF);
    live_flags = 11'h555;
    for (int i = 0; i < 2; i++) begin
      for (int b = 0; b < 22; b++) begin
        logic [31:0] st;
        st = status_exp(11'h7FF, 11'h555);
        wr(i == 0 ? 12'h03C : 12'h040, 32'(1) << b);
        chk("R6 own line", 32'(irq[i]), 32'(st[b]));
        chk("R6 other line", 32'(irq[1-i]), 32'd0);
      end
      wr(i == 0 ? 12'h03C : 12'h040, 32'd0);
    end
    wr(12'h03C, 32'h3F_FFFF);
    live_flags = '0;
    wr(12'h038, 32'h7FF);
    chk("R6 no status no irq", 32'(irq), 32'd0);
    pulse(11'h002);
    chk("R6 set raises line 0", 32'(irq), 32'd1);
    wr(12'h038, 32'h002);
    chk("R6 clear drops line 0", 32'(irq), 32'd0);
    wr(12'h03C, 32'd0);

    // R7 identification
    for (int k = 0; k < 8; k++) begin
      rd(12'(12'hFE0 + 4*k), d);
      chk("R7 id byte", d, 32'(id_tab[k]));
    end

    // R8 read-only views, writes ignored
    resp_words = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    data_count = 16'hBEEF; fifo_count = 16'h0042;
    pulse(11'h041);
    for (int k = 0; k < 4; k++) begin
      wr(12'(12'h014 + 4*k), 32'hFFFF_FFFF);
      rd(12'(12'h014 + 4*k), d);
      chk("R8 response word", d, resp_words[k*32 +: 32]);
    end
    wr(12'h030, 32'h0); rd(12'h030, d); chk("R8 data count", d, 32'h0000_BEEF);
    wr(12'h048, 32'h0); rd(12'h048, d); chk("R8 fifo count", d, 32'h0000_0042);
    wr(12'h034, 32'hFFFF_FFFF); wr(12'hFE0, 32'h0);
    rd(12'h034, d); chk("R8 status write ignored", d, status_exp(11'h041, 11'd0));
    rd(12'hFE0, d); chk("R8 id write ignored", d, 32'h81);

    // R9 FIFO window
    c0 = n_rd;
    for (int k = 0; k < 16; k++) begin
      fifo_rdata = 32'hC0DE_0000 + 32'(k);
      rd(12'(12'h080 + 4*k), d);
      chk("R9 fifo read data", d, 32'hC0DE_0000 + 32'(k));
    end
    @(negedge clk);
    chk("R9 fifo pop count", 32'(n_rd - c0), 32'd16);
    c0 = n_wr;
    wr(12'h0BC, 32'hFEED_F00D); @(negedge clk);
    chk("R9 fifo push count", 32'(n_wr - c0), 32'd1);
    chk("R9 fifo push data", last_fw, 32'hFEED_F00D);

    // R11 unmapped sweep
    wr(12'h000, 32'h11); wr(12'h004, 32'h22); wr(12'h008, 32'h33);
    wr(12'h00C, 32'h44); wr(12'h024, 32'h55); wr(12'h028, 32'h66);
    wr(12'h02C, 32'h77); wr(12'h03C, 32'h88); wr(12'h040, 32'h99);
    @(negedge clk);
    begin
      int s_rd, s_wr, s_cmd, s_dgo;
      s_rd = n_rd; s_wr = n_wr; s_cmd = n_cmd; s_dgo = n_dgo;
      for (int w = 0; w < 1024; w++) begin
        if (!mapped(w)) begin
          wr(12'(4*w), 32'hFFFF_FFFF);
          rd(12'(4*w), d);
          chk("R11 unmapped reads zero", d, 32'd0);
        end
      end
      wr(12'h001, 32'hFFFF_FFFF);
      rd(12'h001, d); chk("R11 misaligned reads zero", d, 32'd0);
      @(negedge clk);
      chk("R11 no strobes", 32'((n_rd - s_rd) + (n_wr - s_wr) + (n_cmd - s_cmd) + (n_dgo - s_dgo)), 32'd0);
    end
    foreach (rw_offs[k]) begin
      rd(12'(rw_offs[k]), d);
      chk("R11 registers untouched", d, 32'(8'h11 * (k + 1)));
    end
    rd(12'h034, d); chk("R11 status untouched", d, status_exp(11'h041, 11'd0));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule